// File: doc/BRIEF.md
# Eye-Statistics Equalizer Setting Selector

This block chooses the setting of a continuous-time linear equalizer from eye-diagram statistics. A slow clock that is asynchronous to the data undersamples the signal. On each clock the block receives one comparator decision, which says whether the equalized signal was above the current reference voltage. For every one of 16 equalizer codes, the block sweeps a 16-step reference DAC code. At each step it counts the comparator ones over a fixed number of sample clocks. From each code's count profile it forms an amplitude histogram, whose bins are the differences between neighbouring levels. The strongest bin and its position are kept per code in a small register file.

When the sweep is over, the block scans that register file and finds the largest peak Sa and the second-largest peak Sb. Picking the strongest peak alone tends to favour an over-equalized setting. So when Sa and Sb lie within a tolerance of each other, the block prefers whichever peak sits at the higher reference position, which means the larger eye amplitude. The chosen code is driven on the equalizer output and held with a done flag until the next start.

Top module: `eye_eq_adapt`

## Requirements
- R1: After a synchronous reset, done_o is 0 and dac_code_o, eq_code_o and sel_code_o are all 0.
- R2: A start pulse accepted on a clock edge makes dac_code_o and eq_code_o read 0 after that edge. Each level lasts settle+SAMPLES cycles. After each level dac_code_o steps by one, wrapping after 15, and eq_code_o steps by one when the reference code wraps. eq_code_o bits [3:2] are the resistor field and bits [1:0] are the capacitor field, so the capacitor field varies fastest.
- R3: settle_i is captured at start. The first settle cycles of every level are not counted. The comparator reaches the counter through a two-flop synchronizer, so with settle of at least 2 every counted sample was taken while the level's codes were on the outputs.
- R4: A level count saturates at 2^CNT_W-1 instead of wrapping.
- R5: For each equalizer code, bin j (j = 0..14) is |count(j) - count(j+1)|. The code's peak is the largest bin, with the lowest j winning a tie.
- R6: Sa is the largest per-code peak, with the lowest code winning a tie. Sb is the largest peak among the remaining codes, again with the lowest code winning a tie. When Sa-Sb is not below the tolerance, the selection is Sa's code.
- R7: tol_i is captured at start. When Sa-Sb is strictly below the tolerance and Sb's bin index is greater than Sa's, the selection is Sb's code.
- R8: done_o rises 256*(settle+SAMPLES)+18 edges after the start edge. It then stays high, with eq_code_o and sel_code_o both equal to the selection and dac_code_o at 0, until the next accepted start. In the 18 cycles before done_o rises, both codes read 0.
- R9: A start pulse that arrives while a sweep or evaluation is in progress is ignored.
- R10: sel_code_o reads 0 from the start edge until the result appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an adaptation (accepted when idle or done) |
| cmp_i | input | 1 | Comparator decision: signal above reference |
| settle_i | input | SETTLE_W | Cycles skipped at the start of each level |
| tol_i | input | CNT_W | Tolerance for the two-peak test |
| dac_code_o | output | LVL_W | Reference DAC code |
| eq_code_o | output | EQ_W | Equalizer code {resistor, capacitor} |
| sel_code_o | output | EQ_W | Selected equalizer code (valid with done_o) |
| done_o | output | 1 | Adaptation complete |

## Verification
Every result is due at a fixed cycle counted from the edge that accepts start. The codes change on that edge and again after every settle+SAMPLES cycles. They read 0 for 18 cycles after the last level, and the selection with done_o appears 256*(settle+SAMPLES)+18 edges after start. A behavioural model in the bench advances on the same edges and compares all four outputs on every falling edge. The comparator stimulus depends only on the codes currently on the outputs and a free-running phase, so the count at each level is known exactly whenever settle is 2 or more, and the bench computes the histogram and selection on its own. A run with settle 0 checks only timing, and a start pulse injected in the middle of a sweep must leave the compared sequence unchanged.

// File: rtl/eqa_pkg.sv
package eqa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWEEP,
    ST_SCAN,
    ST_DECIDE,
    ST_DONE
  } eqa_state_e;
endpackage

// File: rtl/eqa_sync2.sv
module eqa_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk) begin
    if (rst) ff_q <= '0;
    else     ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/eqa_bin_peak.sv
module eqa_bin_peak #(
  parameter int CNT_W = 14,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fin_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] upd_val_o,
  output logic [LVL_W-1:0] upd_idx_o
);
  logic [CNT_W-1:0] prev_q, pk_q, bin;
  logic [LVL_W-1:0] idx_q;
  logic             first, take;

  assign first = (lvl_i == '0);
  assign bin   = (cnt_i > prev_q) ? (cnt_i - prev_q) : (prev_q - cnt_i);
  assign take  = !first && (bin > pk_q);

  always_comb begin
    if (first) begin
      upd_val_o = '0;
      upd_idx_o = '0;
    end else if (take) begin
      upd_val_o = bin;
      upd_idx_o = lvl_i - 1'b1;
    end else begin
      upd_val_o = pk_q;
      upd_idx_o = idx_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pk_q   <= '0;
      idx_q  <= '0;
    end else if (fin_i) begin
      prev_q <= cnt_i;
      pk_q   <= upd_val_o;
      idx_q  <= upd_idx_o;
    end
  end

  // R5: a peak within one code never shrinks from one level to the next
  assert_peak_monotone_R5: assert property (@(posedge clk) disable iff (rst)
    (fin_i && !first) |=> (pk_q >= $past(pk_q)));
endmodule

// File: rtl/eqa_peak_ram.sv
module eqa_peak_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 18,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/eye_eq_adapt.sv
module eye_eq_adapt
  import eqa_pkg::*;
#(
  parameter int SAMPLES  = 8192,
  parameter int CNT_W    = 14,
  parameter int LVL_W    = 4,
  parameter int EQ_W     = 4,
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                cmp_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [CNT_W-1:0]    tol_i,
  output logic [LVL_W-1:0]    dac_code_o,
  output logic [EQ_W-1:0]     eq_code_o,
  output logic [EQ_W-1:0]     sel_code_o,
  output logic                done_o
);
  localparam int N_LVL  = 1 << LVL_W;
  localparam int N_EQ   = 1 << EQ_W;
  localparam int TICK_W = $clog2(SAMPLES + (1 << SETTLE_W));
  localparam int DW     = CNT_W + LVL_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  eqa_state_e          state_q;
  logic [TICK_W-1:0]   tick_q, tick_last;
  logic [CNT_W-1:0]    cnt_q, cnt_nxt;
  logic [LVL_W-1:0]    dac_q;
  logic [EQ_W-1:0]     eq_q, sel_q;
  logic                done_q;
  logic [SETTLE_W-1:0] settle_q;
  logic [CNT_W-1:0]    tol_q;
  logic [EQ_W:0]       k_q;
  logic                cmp_s, count_en, fin;

  // ranking registers for the two strongest per-code peaks
  logic [CNT_W-1:0]    t1_val, t2_val;
  logic [LVL_W-1:0]    t1_idx, t2_idx;
  logic [EQ_W-1:0]     t1_code, t2_code;
  logic                t1_vld, t2_vld;

  logic [CNT_W-1:0]    upd_val;
  logic [LVL_W-1:0]    upd_idx;
  logic                ram_we;
  logic [DW-1:0]       rd_data;
  logic [CNT_W-1:0]    rd_val;
  logic [LVL_W-1:0]    rd_idx;
  logic [EQ_W-1:0]     rd_code;
  logic [EQ_W-1:0]     choice;

  eqa_sync2 #(.STAGES(2)) u_sync (
    .clk (clk), .rst (rst), .d_i (cmp_i), .q_o (cmp_s)
  );

  assign tick_last = TICK_W'(settle_q) + TICK_W'(SAMPLES - 1);
  assign count_en  = (state_q == ST_SWEEP) && (tick_q >= TICK_W'(settle_q));
  assign fin       = (state_q == ST_SWEEP) && (tick_q == tick_last);

  always_comb begin
    cnt_nxt = cnt_q;
    if (count_en && cmp_s && (cnt_q != CNT_MAX)) cnt_nxt = cnt_q + 1'b1;
  end

  eqa_bin_peak #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_peak (
    .clk       (clk),
    .rst       (rst),
    .fin_i     (fin),
    .lvl_i     (dac_q),
    .cnt_i     (cnt_nxt),
    .upd_val_o (upd_val),
    .upd_idx_o (upd_idx)
  );

  assign ram_we = fin && (dac_q == LVL_W'(N_LVL - 1));

  eqa_peak_ram #(.DEPTH(N_EQ), .DW(DW)) u_ram (
    .clk     (clk),
    .we_i    (ram_we),
    .waddr_i (eq_q),
    .wdata_i ({upd_val, upd_idx}),
    .raddr_i (k_q[EQ_W-1:0]),
    .rdata_o (rd_data)
  );

  assign rd_val  = rd_data[DW-1:LVL_W];
  assign rd_idx  = rd_data[LVL_W-1:0];
  assign rd_code = EQ_W'(k_q - 1'b1);

  always_comb begin
    if (((t1_val - t2_val) < tol_q) && (t2_idx > t1_idx)) choice = t2_code;
    else                                                   choice = t1_code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      tick_q   <= '0;
      cnt_q    <= '0;
      dac_q    <= '0;
      eq_q     <= '0;
      sel_q    <= '0;
      done_q   <= 1'b0;
      settle_q <= '0;
      tol_q    <= '0;
      k_q      <= '0;
      t1_val   <= '0; t1_idx <= '0; t1_code <= '0; t1_vld <= 1'b0;
      t2_val   <= '0; t2_idx <= '0; t2_code <= '0; t2_vld <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            state_q  <= ST_SWEEP;
            tick_q   <= '0;
            cnt_q    <= '0;
            dac_q    <= '0;
            eq_q     <= '0;
            sel_q    <= '0;
            done_q   <= 1'b0;
            settle_q <= settle_i;
            tol_q    <= tol_i;
            t1_vld   <= 1'b0;
            t2_vld   <= 1'b0;
          end
        end
        ST_SWEEP: begin
          if (fin) begin
            tick_q <= '0;
            cnt_q  <= '0;
            dac_q  <= dac_q + 1'b1;
            if (dac_q == LVL_W'(N_LVL - 1)) begin
              eq_q <= eq_q + 1'b1;
              if (eq_q == EQ_W'(N_EQ - 1)) begin
                state_q <= ST_SCAN;
                k_q     <= '0;
              end
            end
          end else begin
            tick_q <= tick_q + 1'b1;
            cnt_q  <= cnt_nxt;
          end
        end
        ST_SCAN: begin
          k_q <= k_q + 1'b1;
          if (k_q != '0) begin
            if (!t1_vld || (rd_val > t1_val)) begin
              t2_val  <= t1_val;  t2_idx <= t1_idx;
              t2_code <= t1_code; t2_vld <= t1_vld;
              t1_val  <= rd_val;  t1_idx <= rd_idx;
              t1_code <= rd_code; t1_vld <= 1'b1;
            end else if (!t2_vld || (rd_val > t2_val)) begin
              t2_val  <= rd_val;  t2_idx <= rd_idx;
              t2_code <= rd_code; t2_vld <= 1'b1;
            end
          end
          if (k_q == (EQ_W + 1)'(N_EQ)) state_q <= ST_DECIDE;
        end
        ST_DECIDE: begin
          done_q  <= 1'b1;
          eq_q    <= choice;
          sel_q   <= choice;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dac_code_o = dac_q;
  assign eq_code_o  = eq_q;
  assign sel_code_o = sel_q;
  assign done_o     = done_q;

  // R3: inside a level the codes on the outputs do not move
  assert_codes_steady_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SWEEP && tick_q != '0) |-> ($stable(dac_code_o) && $stable(eq_code_o)));

  // R2: the reference code steps by one at a level end, equalizer code unchanged
  assert_level_step_R2: assert property (@(posedge clk) disable iff (rst)
    (fin && dac_q != LVL_W'(N_LVL - 1)) |=>
      ((dac_code_o == LVL_W'($past(dac_code_o) + 1'b1)) && $stable(eq_code_o)));

  // R4: a saturated count stays saturated until the level ends
  assert_sat_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SWEEP && !fin && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R8: the result is held while no start arrives
  assert_done_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (done_o && $stable(sel_code_o) && $stable(eq_code_o)));

  // R9: a start during a sweep disturbs nothing
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SWEEP && !fin && start_i) |=>
      ($stable(dac_code_o) && $stable(eq_code_o) && !done_o));
endmodule

// File: tb/tb_eye_eq_adapt.sv
`timescale 1ns/1ps
module tb_eye_eq_adapt;
  localparam int M  = 40;
  localparam int CW = 5;
  localparam int CMAX = (1 << CW) - 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start_i = 1'b0;
  logic           cmp_i = 1'b0;
  logic [3:0]     settle_i = 4'd2;
  logic [CW-1:0]  tol_i = '0;
  logic [3:0]     dac_code_o, eq_code_o, sel_code_o;
  logic           done_o;

  eye_eq_adapt #(.SAMPLES(M), .CNT_W(CW), .LVL_W(4), .EQ_W(4), .SETTLE_W(4)) dut (
    .clk (clk), .rst (rst), .start_i (start_i), .cmp_i (cmp_i),
    .settle_i (settle_i), .tol_i (tol_i),
    .dac_code_o (dac_code_o), .eq_code_o (eq_code_o),
    .sel_code_o (sel_code_o), .done_o (done_o)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int scen = 0;
  int tcount = 0;
  bit reported = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  // analog stand-in: level count equals K (clipped) for any window of M consecutive cycles
  function automatic int kval(input int sc, input int e, input int j);
    int hi, edg;
    hi = 5;
    edg = (e % 14) + 1;
    if (sc == 0) begin
      if (e == 3)  begin hi = 25; edg = 12; end
      if (e == 10) begin hi = 28; edg = 4;  end
    end else begin
      if (e == 6)  begin hi = 40; edg = 2;  end
      if (e == 12) begin hi = 31; edg = 9;  end
    end
    return (j < edg) ? hi : 0;
  endfunction

  function automatic int expect_sel(input int sc, input int tolv);
    int pk[16];
    int pi[16];
    int sa, sb;
    for (int e = 0; e < 16; e++) begin
      int c[16];
      for (int j = 0; j < 16; j++) begin
        c[j] = kval(sc, e, j);
        if (c[j] > CMAX) c[j] = CMAX;
      end
      pk[e] = 0; pi[e] = 0;
      for (int j = 0; j < 15; j++) begin
        int b;
        b = (c[j] > c[j+1]) ? c[j] - c[j+1] : c[j+1] - c[j];
        if (b > pk[e]) begin pk[e] = b; pi[e] = j; end
      end
    end
    sa = 0;
    for (int e = 1; e < 16; e++) if (pk[e] > pk[sa]) sa = e;
    sb = -1;
    for (int e = 0; e < 16; e++)
      if (e != sa && (sb < 0 || pk[e] > pk[sb])) sb = e;
    if ((pk[sa] - pk[sb] < tolv) && (pi[sb] > pi[sa])) return sb;
    return sa;
  endfunction

  always @(negedge clk) begin
    cmp_i = ((tcount % M) < kval(scen, eq_code_o, dac_code_o));
    tcount++;
  end

  // behavioural model advanced on each rising edge
  bit m_busy = 0, m_done = 0, m_chk = 1;
  int m_dac = 0, m_eq = 0, m_sel = 0, m_n = 0, m_t = 0, m_exp = 0;
  bit res_check = 1;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_dac = 0; m_eq = 0; m_sel = 0;
    end else if (!m_busy && start_i) begin
      m_busy = 1; m_n = 0; m_dac = 0; m_eq = 0; m_sel = 0; m_done = 0;
      m_t = int'(settle_i) + M;
      m_exp = expect_sel(scen, int'(tol_i));
      m_chk = res_check;
    end else if (m_busy) begin
      m_n++;
      if (m_n < 256 * m_t) begin
        m_eq = (m_n / m_t) / 16;
        m_dac = (m_n / m_t) % 16;
      end else if (m_n < 256 * m_t + 18) begin
        m_eq = 0; m_dac = 0;
      end else begin
        m_done = 1; m_busy = 0; m_eq = m_exp; m_sel = m_exp;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R2", "dac_code_o per cycle", int'(dac_code_o), m_dac);
      check("R8", "done_o per cycle", int'(done_o), int'(m_done));
      if (!m_done || m_chk) begin
        check(m_done ? "R6" : "R2", "eq_code_o per cycle", int'(eq_code_o), m_eq);
        check("R10", "sel_code_o per cycle", int'(sel_code_o), m_sel);
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      errors++;
      $display("FAIL R8 watchdog: done_o actual %0d expected 1", done_o);
      report();
      $finish;
    end
  end

  task automatic run_one(input int sc, input int st, input int tl, input bit poke,
                         input bit chk, input string tag);
    int lat, exp_sel, tm;
    scen = sc;
    settle_i = 4'(st);
    tol_i = CW'(tl);
    res_check = chk;
    tm = st + M;
    exp_sel = expect_sel(sc, tl);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    lat = 0;
    while (!done_o && lat < 150000) begin
      @(negedge clk);
      lat++;
      start_i = (poke && lat == 500);
      if (poke && lat == 503) begin
        // R9: pulse at 500 ignored, sweep position unchanged
        check("R9", "done_o after mid-sweep start", int'(done_o), 0);
        check("R9", "dac_code_o after mid-sweep start", int'(dac_code_o), (503 / tm) % 16);
      end
    end
    start_i = 0;
    // R3 and R8: level length includes settle, result latency fixed
    check("R3", "cycles from start to done_o", lat, 256 * tm + 18);
    if (chk) begin
      check(tag, "sel_code_o result", int'(sel_code_o), exp_sel);
      check(tag, "eq_code_o result", int'(eq_code_o), exp_sel);
    end
    repeat (20) @(negedge clk);
    check("R8", "done_o held", int'(done_o), 1);
    check("R8", "dac_code_o at rest", int'(dac_code_o), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1", "done_o after reset", int'(done_o), 0);
    check("R1", "dac_code_o after reset", int'(dac_code_o), 0);
    check("R1", "eq_code_o after reset", int'(eq_code_o), 0);
    check("R1", "sel_code_o after reset", int'(sel_code_o), 0);
    run_one(0, 2, 0, 0, 1, "R6");   // R6: clear winner, expected code 10
    run_one(0, 5, 8, 1, 1, "R7");   // R7: near peaks, higher index wins, code 3
    run_one(0, 2, 3, 0, 1, "R6");   // R6: difference equals tolerance, code 10
    run_one(1, 3, 0, 0, 1, "R4");   // R4 and R5: saturated tie, lowest code 6
    run_one(1, 2, 1, 0, 1, "R7");   // R7: tie inside tolerance, code 12
    run_one(0, 0, 0, 0, 0, "R3");   // R3: no settle, timing only
    report();
    $finish;
  end
endmodule